// File: doc/BRIEF.md
# Programmable Parallel-RGB Display Timing Generator

This block produces the line and frame timing for a parallel RGB display panel. It runs on the pixel clock and drives a horizontal sync, a vertical sync, a data-enable window, the column and row of the current visible pixel, and a one-clock frame marker. A pixel source reads the coordinates and presents the pixel data while the data-enable window is open.

Every timing length is a run-time input, so one instance can serve panels from small QVGA glass up to WVGA and beyond. The lengths are the visible span, the front porch, the sync pulse and the back porch, each given separately for the horizontal and vertical axes. The three control outputs each have their own polarity select. The inputs are sampled only at the boundary between frames, so a frame never mixes timing sets.

Top module: `panel_timing_gen`

## Requirements
- R1: A line lasts `cfg_h_active + cfg_h_front + cfg_h_sync + cfg_h_back` pixel clocks. Counting from line position 0, the line runs through the visible span, then the front porch, then the sync pulse, then the back porch. Horizontal sync is asserted exactly while the position lies in the sync pulse.
- R2: A frame lasts `cfg_v_active + cfg_v_front + cfg_v_sync + cfg_v_back` lines, in the same region order as a line. Vertical sync is asserted for every pixel clock of each sync line, starting at the first pixel of that line.
- R3: Data enable is asserted only when the horizontal position is in the visible span and the current line is a visible line.
- R4: `cfg_pol_inv[0]`, `cfg_pol_inv[1]` and `cfg_pol_inv[2]` select the polarity of hsync, vsync and de respectively. A value of 0 means active-high and 1 means active-low. Each bit acts independently of the others.
- R5: While data enable is asserted, `col` and `row` give the pixel's position within the visible area, each counting from 0. While it is deasserted, both are 0.
- R6: `frame_start` is active-high. It is asserted for exactly one pixel clock, at the first pixel of the first vertical sync line of each frame.
- R7: All configuration inputs, including the polarities, are sampled on the first clock after reset release and again at each frame boundary. The frame boundary is the step from the last pixel of the back porch on the last line to the first visible pixel. A change made during a frame has no effect until the next frame.
- R8: While `rst_n` is low (after at least two clock edges), hsync, vsync and de sit at their inactive levels for the present polarity inputs, and `col`, `row` and `frame_start` are 0. After release, the outputs for pixel (0,0) appear after the second rising edge.
- R9: Each length is 12 bits wide. The visible and sync lengths may range from 1 to 4095 and the porches from 0 to 4095. This range covers an 800x480 area in a 928-clock line and a 525-line frame, back porches as short as 8 pixels and 2 lines, and a front porch of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_h_active | input | 12 | Visible pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch, pixel clocks |
| cfg_h_sync | input | 12 | Horizontal sync width, pixel clocks |
| cfg_h_back | input | 12 | Horizontal back porch, pixel clocks |
| cfg_v_active | input | 12 | Visible lines per frame |
| cfg_v_front | input | 12 | Vertical front porch, lines |
| cfg_v_sync | input | 12 | Vertical sync width, lines |
| cfg_v_back | input | 12 | Vertical back porch, lines |
| cfg_pol_inv | input | 3 | Active-low selects: bit0 hsync, bit1 vsync, bit2 de |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| col | output | 12 | Visible column, 0 outside the window |
| row | output | 12 | Visible row, 0 outside the window |
| frame_start | output | 1 | One-clock marker at the start of vertical sync |

## Verification
The bench changes the geometry and the polarities in the middle of a frame. A design that took the new values at once would produce a frame whose first half follows one timing set and whose second half follows another, or would flip a polarity partway through a line. A zero front porch puts the sync line directly after the last visible line and the sync pulse directly after the last visible pixel, so an off-by-one in the region bounds shows up as a shifted or missing sync. A 928-clock line with 800 visible pixels drives the column counter through the hundreds, where a truncated counter or total would wrap early. A reset taken with all three outputs set active-low must leave them high, which a design that resets the pins themselves to 0 would get wrong.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  parameter int unsigned PTG_CW = 12;

  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } sync_bits_t;
endpackage

// File: rtl/ptg_axis_counter.sv
module ptg_axis_counter #(
  parameter int unsigned CW = ptg_pkg::PTG_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  output logic [CW-1:0] pos,
  output logic          in_act,
  output logic          in_sync,
  output logic          sync_first,
  output logic          at_first,
  output logic          at_last
);
  localparam int unsigned SW = CW + 2;

  logic [SW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] act_end, front_end, sync_end, last_pos;

  always_comb begin
    act_end   = SW'(len_act);
    front_end = act_end + SW'(len_front);
    sync_end  = front_end + SW'(len_sync);
    last_pos  = sync_end + SW'(len_back) - SW'(1);
  end

  always_comb begin
    in_act     = cnt_q < act_end;
    in_sync    = (cnt_q >= front_end) && (cnt_q < sync_end);
    sync_first = cnt_q == front_end;
    at_first   = cnt_q == '0;
    at_last    = cnt_q == last_pos;
    pos        = cnt_q[CW-1:0];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_last ? '0 : cnt_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R1
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_pos));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && at_last) |=> (cnt_q == '0));
endmodule

// File: rtl/ptg_cfg_shadow.sv
module ptg_cfg_shadow #(
  parameter int unsigned CW = ptg_pkg::PTG_CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CW-1:0]       h_act_i,
  input  logic [CW-1:0]       h_fp_i,
  input  logic [CW-1:0]       h_sw_i,
  input  logic [CW-1:0]       h_bp_i,
  input  logic [CW-1:0]       v_act_i,
  input  logic [CW-1:0]       v_fp_i,
  input  logic [CW-1:0]       v_sw_i,
  input  logic [CW-1:0]       v_bp_i,
  input  ptg_pkg::sync_bits_t pol_i,
  output logic [CW-1:0]       h_act_q,
  output logic [CW-1:0]       h_fp_q,
  output logic [CW-1:0]       h_sw_q,
  output logic [CW-1:0]       h_bp_q,
  output logic [CW-1:0]       v_act_q,
  output logic [CW-1:0]       v_fp_q,
  output logic [CW-1:0]       v_sw_q,
  output logic [CW-1:0]       v_bp_q,
  output ptg_pkg::sync_bits_t pol_q
);
  // Datapath holding registers: no reset, written only under load.
  always_ff @(posedge clk) begin
    if (load) begin
      h_act_q <= h_act_i;
      h_fp_q  <= h_fp_i;
      h_sw_q  <= h_sw_i;
      h_bp_q  <= h_bp_i;
      v_act_q <= v_act_i;
      v_fp_q  <= v_fp_i;
      v_sw_q  <= v_sw_i;
      v_bp_q  <= v_bp_i;
      pol_q   <= pol_i;
    end
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(h_act_q) && $stable(h_fp_q) && $stable(h_sw_q) && $stable(h_bp_q) &&
               $stable(v_act_q) && $stable(v_fp_q) && $stable(v_sw_q) && $stable(v_bp_q) &&
               $stable(pol_q)));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int unsigned CW = ptg_pkg::PTG_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_h_active,
  input  logic [CW-1:0] cfg_h_front,
  input  logic [CW-1:0] cfg_h_sync,
  input  logic [CW-1:0] cfg_h_back,
  input  logic [CW-1:0] cfg_v_active,
  input  logic [CW-1:0] cfg_v_front,
  input  logic [CW-1:0] cfg_v_sync,
  input  logic [CW-1:0] cfg_v_back,
  input  logic [2:0]    cfg_pol_inv,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] col,
  output logic [CW-1:0] row,
  output logic          frame_start
);
  import ptg_pkg::*;

  logic run_q;
  logic load, wrap;

  logic [CW-1:0] h_act, h_fp, h_sw, h_bp, v_act, v_fp, v_sw, v_bp;
  sync_bits_t    pol_in, pol_cur, pol_out_q;

  logic [CW-1:0] h_pos, v_pos;
  logic          h_in_act, h_in_sync, h_sync_first, h_first, h_last;
  logic          v_in_act, v_in_sync, v_sync_first, v_first, v_last;

  sync_bits_t    raw_d, raw_q;
  logic          fs_d, fs_q;
  logic [CW-1:0] col_d, col_q, row_d, row_q;

  assign pol_in = sync_bits_t'({cfg_pol_inv[2], cfg_pol_inv[1], cfg_pol_inv[0]});
  assign wrap   = run_q && h_last && v_last;
  assign load   = !run_q || wrap;

  ptg_cfg_shadow #(.CW(CW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .h_act_i (cfg_h_active),
    .h_fp_i  (cfg_h_front),
    .h_sw_i  (cfg_h_sync),
    .h_bp_i  (cfg_h_back),
    .v_act_i (cfg_v_active),
    .v_fp_i  (cfg_v_front),
    .v_sw_i  (cfg_v_sync),
    .v_bp_i  (cfg_v_back),
    .pol_i   (pol_in),
    .h_act_q (h_act),
    .h_fp_q  (h_fp),
    .h_sw_q  (h_sw),
    .h_bp_q  (h_bp),
    .v_act_q (v_act),
    .v_fp_q  (v_fp),
    .v_sw_q  (v_sw),
    .v_bp_q  (v_bp),
    .pol_q   (pol_cur)
  );

  ptg_axis_counter #(.CW(CW)) u_hax (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .step       (1'b1),
    .len_act    (h_act),
    .len_front  (h_fp),
    .len_sync   (h_sw),
    .len_back   (h_bp),
    .pos        (h_pos),
    .in_act     (h_in_act),
    .in_sync    (h_in_sync),
    .sync_first (h_sync_first),
    .at_first   (h_first),
    .at_last    (h_last)
  );

  ptg_axis_counter #(.CW(CW)) u_vax (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .step       (h_last),
    .len_act    (v_act),
    .len_front  (v_fp),
    .len_sync   (v_sw),
    .len_back   (v_bp),
    .pos        (v_pos),
    .in_act     (v_in_act),
    .in_sync    (v_in_sync),
    .sync_first (v_sync_first),
    .at_first   (v_first),
    .at_last    (v_last)
  );

  // Decode of the counter state into the next output values.
  always_comb begin
    raw_d = '0;
    fs_d  = 1'b0;
    col_d = '0;
    row_d = '0;
    if (run_q) begin
      raw_d.hs = h_in_sync;
      raw_d.vs = v_in_sync;
      raw_d.de = h_in_act && v_in_act;
      fs_d     = v_sync_first && h_first;
      if (raw_d.de) begin
        col_d = h_pos;
        row_d = v_pos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      raw_q <= '0;
      fs_q  <= 1'b0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      run_q <= 1'b1;
      raw_q <= raw_d;
      fs_q  <= fs_d;
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // Polarity travels one stage behind the shadow so it lines up with raw_q.
  always_ff @(posedge clk) begin
    pol_out_q <= pol_cur;
  end

  assign hsync       = raw_q.hs ^ pol_out_q.hs;
  assign vsync       = raw_q.vs ^ pol_out_q.vs;
  assign de          = raw_q.de ^ pol_out_q.de;
  assign col         = col_q;
  assign row         = row_q;
  assign frame_start = fs_q;

  // R3
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q.de |-> (!raw_q.hs && !raw_q.vs));

  // R5
  col_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q.de) |-> (col_q == '0));

  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q.de && $past(raw_q.de)) |-> (col_q == $past(col_q) + CW'(1) && row_q == $past(row_q)));

  // R6
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);

  // R6
  fs_in_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (raw_q.vs && !raw_q.de));
endmodule

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;
  localparam int CW = 12;

  typedef struct {
    logic          hs;
    logic          vs;
    logic          de;
    logic          fs;
    logic [CW-1:0] col;
    logic [CW-1:0] row;
  } pix_t;

  typedef struct {
    int ha, hf, hs, hb;
    int va, vf, vs, vb;
    logic [2:0] pol;
  } geo_t;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] h_a, h_f, h_s, h_b, v_a, v_f, v_s, v_b;
  logic [2:0]    pol;
  logic          hsync, vsync, de, frame_start;
  logic [CW-1:0] col, row;

  int   checks;
  int   failures;
  pix_t exp_q[$];

  panel_timing_gen u_panel_timing_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_h_active (h_a),
    .cfg_h_front  (h_f),
    .cfg_h_sync   (h_s),
    .cfg_h_back   (h_b),
    .cfg_v_active (v_a),
    .cfg_v_front  (v_f),
    .cfg_v_sync   (v_s),
    .cfg_v_back   (v_b),
    .cfg_pol_inv  (pol),
    .hsync        (hsync),
    .vsync        (vsync),
    .de           (de),
    .col          (col),
    .row          (row),
    .frame_start  (frame_start)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic apply(geo_t g);
    h_a = CW'(g.ha); h_f = CW'(g.hf); h_s = CW'(g.hs); h_b = CW'(g.hb);
    v_a = CW'(g.va); v_f = CW'(g.vf); v_s = CW'(g.vs); v_b = CW'(g.vb);
    pol = g.pol;
  endtask

  // Driver: expected stream of one whole frame, built from the requirements.
  task automatic push_frame(geo_t g);
    int ht = g.ha + g.hf + g.hs + g.hb;
    int vt = g.va + g.vf + g.vs + g.vb;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        pix_t p;
        logic hs_on, vs_on, de_on;
        hs_on = (h >= g.ha + g.hf) && (h < g.ha + g.hf + g.hs);
        vs_on = (v >= g.va + g.vf) && (v < g.va + g.vf + g.vs);
        de_on = (h < g.ha) && (v < g.va);
        p.hs  = hs_on ^ g.pol[0];
        p.vs  = vs_on ^ g.pol[1];
        p.de  = de_on ^ g.pol[2];
        p.fs  = (v == g.va + g.vf) && (h == 0);
        p.col = de_on ? CW'(h) : '0;
        p.row = de_on ? CW'(v) : '0;
        exp_q.push_back(p);
      end
    end
  endtask

  // Monitor: pixel (0,0) appears after the second rising edge past release (R8).
  task automatic monitor(string tag);
    repeat (2) @(posedge clk);
    while (exp_q.size() > 0) begin
      pix_t e;
      @(negedge clk);
      e = exp_q.pop_front();
      chk({"R1 hsync ", tag}, int'(hsync), int'(e.hs));
      chk({"R2 vsync ", tag}, int'(vsync), int'(e.vs));
      chk({"R3 de ", tag}, int'(de), int'(e.de));
      chk({"R5 col ", tag}, int'(col), int'(e.col));
      chk({"R5 row ", tag}, int'(row), int'(e.row));
      chk({"R6 frame_start ", tag}, int'(frame_start), int'(e.fs));
    end
  endtask

  task automatic reset_and_check(logic [2:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R8: inactive levels follow the polarity selects
    chk("R8 reset hsync", int'(hsync), int'(p[0]));
    chk("R8 reset vsync", int'(vsync), int'(p[1]));
    chk("R8 reset de", int'(de), int'(p[2]));
    chk("R8 reset col", int'(col), 0);
    chk("R8 reset row", int'(row), 0);
    chk("R8 reset frame_start", int'(frame_start), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    geo_t ga, gb, gc;
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;

    // R9: QVGA-style back porches of 8 pixels and 2 lines
    ga = '{ha: 8, hf: 2, hs: 3, hb: 8, va: 4, vf: 1, vs: 2, vb: 2, pol: 3'b000};
    // R4 and R9: zero front porches, hsync and de active-low
    gb = '{ha: 5, hf: 0, hs: 1, hb: 3, va: 3, vf: 0, vs: 1, vb: 2, pol: 3'b101};
    // R9: 800 visible pixels in a 928-clock line, all outputs active-low (R4)
    gc = '{ha: 800, hf: 40, hs: 48, hb: 40, va: 2, vf: 1, vs: 1, vb: 2, pol: 3'b111};

    // Scenario 1, R7: change inputs mid-frame; the next frame picks them up.
    apply(ga);
    reset_and_check(ga.pol);
    push_frame(ga);
    push_frame(ga);
    push_frame(gb);
    push_frame(gb);
    rst_n = 1'b1;
    fork
      monitor("R7 R4 s1");
      begin
        // frame 0 spans edges 1..189, frame 1 edges 190..378
        repeat (284) @(posedge clk);
        @(negedge clk);
        apply(gb);
      end
    join

    // Scenario 2, R9: wide line with active-low outputs through reset.
    apply(gc);
    reset_and_check(gc.pol);
    push_frame(gc);
    push_frame(gc);
    rst_n = 1'b1;
    monitor("R9 R4 s2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule